// File: doc/BRIEF.md
# Strap-Configured Clock Stop Controller

This block sits between the clock sources of a multi-output clock generator and its output pads. It reads configuration straps once after power-on reset, then holds them. The straps are a two-bit frequency select, which goes on to the frequency synthesizer, and a mode bit. The pins that carry the straps are later reused as clock outputs, so pad drive on them is held off until the straps have been captured.

The mode bit decides the role of four shared pins. With mode high they drive extra memory clocks, and power management is off. With mode low they become active-low requests: CPU stop, PCI stop, power-down and AGP stop. Each clock group has its own gate. A stop request passes through a synchronizer in that group's own clock domain. The gate enable then changes only while that clock is low, so outputs stop and restart with whole high phases only.

A programmable output runs at either the 48 MHz input rate or half of it. A register bit, delivered here as a plain input, picks the rate. The switch happens only while both candidate clocks are low.

Top module: `clk_stop_ctrl`

## Requirements
- R1: On the first `ref_clk_i` rising edge after `rst_ni` goes high, `fs_strap_i` and `mode_strap_i` are captured to `fs_o` and `mode_o`. Those outputs then stay fixed until the next reset, whatever the strap inputs do.
- R2: Until the straps are captured, `pad_oe_o` is 0, `shr_oe_o` is 0 and every clock output is low. Once the straps are captured, `pad_oe_o` is 1.
- R3: With mode captured as 1, `shr_oe_o` is 4'b1111 and each `shr_o` bit carries the memory clock. `shr_i` is ignored, and no clock group is stopped.
- R4: With mode captured as 0, `shr_oe_o` and `shr_o` are 0. Each `shr_i` bit is an active-low request, by bit: bit 0 is CPU stop, bit 1 is PCI stop, bit 2 is power-down and bit 3 is AGP stop.
- R5: With mode 0 and `shr_i[0]` low, `cpu_clk_o` rests low within four CPU clock cycles. It resumes once the bit returns high.
- R6: With mode 0 and `shr_i[1]` low, `pci_clk_o` rests low, while `pci_f_clk_o` keeps toggling.
- R7: With mode 0 and `shr_i[3]` low, `agp_clk_o` rests low.
- R8: With mode 0 and `shr_i[2]` low, every clock output rests low: CPU, PCI, free-running PCI, AGP, memory, reference and the programmable output.
- R9: With `sel24_i` at 0, `usb_clk_o` follows `clk48_i`. With `sel24_i` at 1, `usb_clk_o` runs at half that rate. The select changes only while both the input and the halved clock are low.
- R10: Gated outputs never show a runt pulse. Every high phase of `cpu_clk_o` is a full high phase of `cpu_clk_i`, including across stop and restart.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rst_ni | input | 1 | Active-low asynchronous power-on reset |
| cpu_clk_i | input | 1 | CPU clock source |
| pci_clk_i | input | 1 | PCI clock source |
| agp_clk_i | input | 1 | AGP clock source |
| sdram_clk_i | input | 1 | Memory clock source |
| ref_clk_i | input | 1 | Reference clock, also clocks strap capture |
| clk48_i | input | 1 | 48 MHz source for the programmable output |
| fs_strap_i | input | 2 | Frequency-select strap levels |
| mode_strap_i | input | 1 | Mode strap level |
| sel24_i | input | 1 | Register bit: 1 selects half rate |
| shr_i | input | 4 | Shared pin input levels |
| shr_o | output | 4 | Shared pin output values |
| shr_oe_o | output | 4 | Shared pin output enables |
| pad_oe_o | output | 1 | Output enable for the strap pins |
| fs_o | output | 2 | Captured frequency select |
| mode_o | output | 1 | Captured mode |
| cpu_clk_o | output | 2 | Gated CPU clocks |
| pci_clk_o | output | 5 | Gated PCI clocks |
| pci_f_clk_o | output | 1 | Free-running PCI clock |
| agp_clk_o | output | 2 | Gated AGP clocks |
| sdram_clk_o | output | 9 | Gated memory clocks |
| ref_clk_o | output | 1 | Gated reference clock |
| usb_clk_o | output | 1 | Programmable 48/24 MHz output |

## Verification
A synchronizer stage stuck in its reset state would show up as a group that never starts after reset, or one that never stops. The bench sees this within a few cycles of its first random stop pattern. A group decoded from the wrong shared pin shows a pattern-dependent mismatch on one group's output during the random phase. A gate enable that moves on the wrong clock edge cuts a high phase, and the pulse-width monitor catches it on the next stop or restart. A strap register that keeps loading after reset shows a changed `fs_o` as soon as the strap inputs are toggled.

// File: rtl/clk_stop_pkg.sv
package clk_stop_pkg;
  localparam int FS_W  = 2;
  localparam int SHR_N = 4;

  // shared pin roles when power management is on
  localparam int SHR_CPU = 0;
  localparam int SHR_PCI = 1;
  localparam int SHR_PD  = 2;
  localparam int SHR_AGP = 3;

  // gated clock groups
  localparam int G_CPU  = 0;
  localparam int G_PCI  = 1;
  localparam int G_PCIF = 2;
  localparam int G_AGP  = 3;
  localparam int G_SDR  = 4;
  localparam int G_REF  = 5;
  localparam int G_N    = 6;

  typedef struct packed {
    logic [FS_W-1:0] fs;
    logic            mode;
  } strap_t;
endpackage

// File: rtl/clk_strap_latch.sv
module clk_strap_latch
  import clk_stop_pkg::*;
(
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [FS_W-1:0] fs_i,
  input  logic            mode_i,
  output strap_t          strap_o,
  output logic            done_o
);
  strap_t strap_q;
  logic   done_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      strap_q <= '0;
      done_q  <= 1'b0;
    end else if (!done_q) begin
      strap_q <= '{fs: fs_i, mode: mode_i};
      done_q  <= 1'b1;
    end
  end

  assign strap_o = strap_q;
  assign done_o  = done_q;

  // R1
  strap_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_q |=> (done_q && $stable(strap_q)));
endmodule

// File: rtl/clk_gate_sync.sv
module clk_gate_sync #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic stop_i,
  output logic clk_o
);
  localparam int LAST = SYNC_STAGES - 1;

  logic [SYNC_STAGES-1:0] sync_q;
  logic                   en_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q <= '1;
    else         sync_q <= {sync_q[SYNC_STAGES-2:0], stop_i};
  end

  // enable moves on the falling edge only: whole high phases
  always_ff @(negedge clk_i or negedge rst_ni) begin
    if (!rst_ni) en_q <= 1'b0;
    else         en_q <= ~sync_q[LAST];
  end

  assign clk_o = clk_i & en_q;

  // R10
  gate_open_chk: assert property (@(negedge clk_i) disable iff (!rst_ni)
    $rose(en_q) |-> !$past(sync_q[LAST]));
  // R5
  gate_close_chk: assert property (@(negedge clk_i) disable iff (!rst_ni)
    $fell(en_q) |-> $past(sync_q[LAST]));
endmodule

// File: rtl/clk_freq_sel.sv
module clk_freq_sel #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic half_i,
  input  logic stop_i,
  output logic clk_o
);
  localparam int LAST = SYNC_STAGES - 1;

  logic                   div_q;
  logic [SYNC_STAGES-1:0] sel_sync_q;
  logic [SYNC_STAGES-1:0] stop_sync_q;
  logic                   sel_q;
  logic                   en_q;
  logic                   mux_clk;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      div_q       <= 1'b0;
      sel_sync_q  <= '0;
      stop_sync_q <= '1;
    end else begin
      div_q       <= ~div_q;
      sel_sync_q  <= {sel_sync_q[SYNC_STAGES-2:0], half_i};
      stop_sync_q <= {stop_sync_q[SYNC_STAGES-2:0], stop_i};
    end
  end

  // update only when both candidate clocks are low
  always_ff @(negedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sel_q <= 1'b0;
      en_q  <= 1'b0;
    end else if (!div_q) begin
      sel_q <= sel_sync_q[LAST];
      en_q  <= ~stop_sync_q[LAST];
    end
  end

  assign mux_clk = sel_q ? div_q : clk_i;
  assign clk_o   = mux_clk & en_q;

  // R9
  sel_switch_low_chk: assert property (@(negedge clk_i) disable iff (!rst_ni)
    (sel_q != $past(sel_q)) |-> !$past(div_q));
endmodule

// File: rtl/clk_stop_ctrl.sv
module clk_stop_ctrl
  import clk_stop_pkg::*;
#(
  parameter int CPU_N       = 2,
  parameter int PCI_N       = 5,
  parameter int AGP_N       = 2,
  parameter int SDRAM_N     = 9,
  parameter int SYNC_STAGES = 2
) (
  input  logic               rst_ni,
  input  logic               cpu_clk_i,
  input  logic               pci_clk_i,
  input  logic               agp_clk_i,
  input  logic               sdram_clk_i,
  input  logic               ref_clk_i,
  input  logic               clk48_i,
  input  logic [FS_W-1:0]    fs_strap_i,
  input  logic               mode_strap_i,
  input  logic               sel24_i,
  input  logic [SHR_N-1:0]   shr_i,
  output logic [SHR_N-1:0]   shr_o,
  output logic [SHR_N-1:0]   shr_oe_o,
  output logic               pad_oe_o,
  output logic [FS_W-1:0]    fs_o,
  output logic               mode_o,
  output logic [CPU_N-1:0]   cpu_clk_o,
  output logic [PCI_N-1:0]   pci_clk_o,
  output logic               pci_f_clk_o,
  output logic [AGP_N-1:0]   agp_clk_o,
  output logic [SDRAM_N-1:0] sdram_clk_o,
  output logic               ref_clk_o,
  output logic               usb_clk_o
);
  strap_t strap;
  logic   por_done;
  logic   pm_on;
  logic   pd_req;

  logic [G_N-1:0] grp_clk;
  logic [G_N-1:0] grp_stop;
  logic [G_N-1:0] grp_gclk;

  clk_strap_latch u_strap (
    .clk_i   (ref_clk_i),
    .rst_ni  (rst_ni),
    .fs_i    (fs_strap_i),
    .mode_i  (mode_strap_i),
    .strap_o (strap),
    .done_o  (por_done)
  );

  assign pm_on  = por_done & ~strap.mode;
  assign pd_req = pm_on & ~shr_i[SHR_PD];

  assign grp_clk[G_CPU]  = cpu_clk_i;
  assign grp_clk[G_PCI]  = pci_clk_i;
  assign grp_clk[G_PCIF] = pci_clk_i;
  assign grp_clk[G_AGP]  = agp_clk_i;
  assign grp_clk[G_SDR]  = sdram_clk_i;
  assign grp_clk[G_REF]  = ref_clk_i;

  assign grp_stop[G_CPU]  = ~por_done | pd_req | (pm_on & ~shr_i[SHR_CPU]);
  assign grp_stop[G_PCI]  = ~por_done | pd_req | (pm_on & ~shr_i[SHR_PCI]);
  assign grp_stop[G_PCIF] = ~por_done | pd_req;
  assign grp_stop[G_AGP]  = ~por_done | pd_req | (pm_on & ~shr_i[SHR_AGP]);
  assign grp_stop[G_SDR]  = ~por_done | pd_req;
  assign grp_stop[G_REF]  = ~por_done | pd_req;

  for (genvar g = 0; g < G_N; g++) begin : g_gate
    clk_gate_sync #(.SYNC_STAGES(SYNC_STAGES)) u_gate (
      .clk_i  (grp_clk[g]),
      .rst_ni (rst_ni),
      .stop_i (grp_stop[g]),
      .clk_o  (grp_gclk[g])
    );
  end

  clk_freq_sel #(.SYNC_STAGES(SYNC_STAGES)) u_freq (
    .clk_i  (clk48_i),
    .rst_ni (rst_ni),
    .half_i (sel24_i),
    .stop_i (~por_done | pd_req),
    .clk_o  (usb_clk_o)
  );

  assign cpu_clk_o   = {CPU_N{grp_gclk[G_CPU]}};
  assign pci_clk_o   = {PCI_N{grp_gclk[G_PCI]}};
  assign pci_f_clk_o = grp_gclk[G_PCIF];
  assign agp_clk_o   = {AGP_N{grp_gclk[G_AGP]}};
  assign sdram_clk_o = {SDRAM_N{grp_gclk[G_SDR]}};
  assign ref_clk_o   = grp_gclk[G_REF];

  assign pad_oe_o = por_done;
  assign fs_o     = strap.fs;
  assign mode_o   = strap.mode;
  assign shr_oe_o = {SHR_N{por_done & strap.mode}};
  assign shr_o    = shr_oe_o & {SHR_N{grp_gclk[G_SDR]}};

  // R3
  mode_high_oe_chk: assert property (@(posedge sdram_clk_i) disable iff (!rst_ni)
    (pad_oe_o && mode_o) |-> (shr_oe_o == '1));
  // R4
  mode_low_idle_chk: assert property (@(posedge sdram_clk_i) disable iff (!rst_ni)
    !mode_o |-> (shr_oe_o == '0 && shr_o == '0));
  // R2
  pre_strap_quiet_chk: assert property (@(posedge ref_clk_i) disable iff (!rst_ni)
    !pad_oe_o |-> (shr_oe_o == '0 && !ref_clk_o));
endmodule

// File: tb/clk_stop_ctrl_tb.sv
`timescale 1ns/1ps
module clk_stop_ctrl_tb;
  logic       rst_ni = 1'b0;
  logic       clk = 1'b0;
  logic       ref_clk = 1'b0;
  logic       clk48 = 1'b0;
  logic [1:0] fs_strap = 2'b00;
  logic       mode_strap = 1'b0;
  logic       sel24 = 1'b0;
  logic [3:0] shr_in = 4'hF;
  logic [3:0] shr_o, shr_oe_o;
  logic       pad_oe_o, mode_o;
  logic [1:0] fs_o;
  logic [1:0] cpu_clk_o;
  logic [4:0] pci_clk_o;
  logic       pci_f_clk_o;
  logic [1:0] agp_clk_o;
  logic [8:0] sdram_clk_o;
  logic       ref_clk_o, usb_clk_o;

  int tests = 0;
  int fails = 0;
  int runts = 0;
  int usb_edges = 0;
  realtime t_rise = 0.0;

  always #5  clk = ~clk;
  always #7  ref_clk = ~ref_clk;
  always #10 clk48 = ~clk48;

  clk_stop_ctrl u_dut (
    .rst_ni(rst_ni), .cpu_clk_i(clk), .pci_clk_i(clk), .agp_clk_i(clk),
    .sdram_clk_i(clk), .ref_clk_i(ref_clk), .clk48_i(clk48),
    .fs_strap_i(fs_strap), .mode_strap_i(mode_strap), .sel24_i(sel24),
    .shr_i(shr_in), .shr_o(shr_o), .shr_oe_o(shr_oe_o), .pad_oe_o(pad_oe_o),
    .fs_o(fs_o), .mode_o(mode_o), .cpu_clk_o(cpu_clk_o), .pci_clk_o(pci_clk_o),
    .pci_f_clk_o(pci_f_clk_o), .agp_clk_o(agp_clk_o), .sdram_clk_o(sdram_clk_o),
    .ref_clk_o(ref_clk_o), .usb_clk_o(usb_clk_o)
  );

  // R10 pulse-width monitor
  always @(posedge cpu_clk_o[0]) t_rise = $realtime;
  always @(negedge cpu_clk_o[0]) if ($realtime - t_rise != 5.0) runts++;
  always @(posedge usb_clk_o) usb_edges++;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // expected run state per group, from R3/R4/R5-R8
  function automatic logic run_of(input logic mode, input logic [3:0] s, input int grp);
    logic pd_ok;
    pd_ok = s[2];
    if (mode) return 1'b1;
    case (grp)
      0: return pd_ok & s[0];
      1: return pd_ok & s[1];
      3: return pd_ok & s[3];
      default: return pd_ok;
    endcase
  endfunction

  task automatic check_groups(input logic mode, input logic [3:0] s);
    @(posedge clk); #2;
    chk("R5 cpu", {30'd0, cpu_clk_o}, {32{run_of(mode, s, 0)}} & 32'h3);
    chk("R6 pci", {27'd0, pci_clk_o}, {32{run_of(mode, s, 1)}} & 32'h1F);
    chk("R6 pci_f", {31'd0, pci_f_clk_o}, {31'd0, run_of(mode, s, 2)});
    chk("R7 agp", {30'd0, agp_clk_o}, {32{run_of(mode, s, 3)}} & 32'h3);
    chk("R8 sdram", {23'd0, sdram_clk_o}, {32{run_of(mode, s, 4)}} & 32'h1FF);
    if (mode) chk("R3 shr_o", {28'd0, shr_o}, 32'hF);
    else      chk("R4 shr_o", {28'd0, shr_o}, 32'h0);
    @(posedge ref_clk); #2;
    chk("R8 ref", {31'd0, ref_clk_o}, {31'd0, run_of(mode, s, 5)});
    @(posedge clk48); #2;
    chk("R8 usb", {31'd0, usb_clk_o}, {31'd0, run_of(mode, s, 5)});
  endtask

  task automatic do_reset(input logic [1:0] fs, input logic mode);
    rst_ni = 1'b0;
    fs_strap = fs;
    mode_strap = mode;
    repeat (4) @(posedge clk);
    #2;
    chk("R2 pad_oe in reset", {31'd0, pad_oe_o}, 32'd0);
    chk("R2 shr_oe in reset", {28'd0, shr_oe_o}, 32'd0);
    chk("R2 cpu low in reset", {30'd0, cpu_clk_o}, 32'd0);
    @(negedge ref_clk);
    rst_ni = 1'b1;
    @(posedge ref_clk); #1;
    chk("R1 fs captured", {30'd0, fs_o}, {30'd0, fs});
    chk("R1 mode captured", {31'd0, mode_o}, {31'd0, mode});
    chk("R2 pad_oe after capture", {31'd0, pad_oe_o}, 32'd1);
    fs_strap = ~fs;
    mode_strap = ~mode;
    repeat (10) @(posedge clk);
    #1;
    chk("R1 fs held", {30'd0, fs_o}, {30'd0, fs});
    chk("R1 mode held", {31'd0, mode_o}, {31'd0, mode});
    chk("R3/R4 shr_oe", {28'd0, shr_oe_o}, mode ? 32'hF : 32'h0);
  endtask

  task automatic apply(input logic [3:0] s);
    @(negedge clk);
    shr_in = s;
    repeat (12) @(posedge clk);
  endtask

  task automatic count_usb(input logic half, input int exp_edges);
    sel24 = half;
    repeat (10) @(posedge clk48);
    @(negedge clk48);
    usb_edges = 0;
    repeat (20) @(negedge clk48);
    chk("R9 usb edges", usb_edges, exp_edges);
  endtask

  initial begin
    void'($urandom(32'd2024));
    do_reset(2'b10, 1'b0);
    // directed: each request alone, then all released
    apply(4'b1110); check_groups(1'b0, 4'b1110);
    apply(4'b1101); check_groups(1'b0, 4'b1101);
    apply(4'b0111); check_groups(1'b0, 4'b0111);
    apply(4'b1011); check_groups(1'b0, 4'b1011);
    apply(4'b1111); check_groups(1'b0, 4'b1111);
    for (int i = 0; i < 30; i++) begin
      logic [3:0] s;
      s = 4'($urandom);
      apply(s);
      check_groups(1'b0, s);
    end
    apply(4'hF);
    count_usb(1'b0, 20);
    count_usb(1'b1, 10);
    count_usb(1'b0, 20);
    // mode high: shared pins are clocks, requests ignored
    do_reset(2'b01, 1'b1);
    for (int i = 0; i < 12; i++) begin
      logic [3:0] s;
      s = 4'($urandom);
      apply(s);
      check_groups(1'b1, s);
    end
    apply(4'h0);
    check_groups(1'b1, 4'h0);
    chk("R10 no runt pulses", runts, 0);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    #1500us;
    fails++;
    tests++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule